// File: doc/BRIEF.md
# Early-Exit Binary to BCD Converter

This block turns a 16-bit unsigned binary number into five packed BCD digits, one source bit at a time. A start strobe captures the input in a setup cycle. Each following cycle consumes the lowest remaining source bit. A running decimal weight (1, 2, 4, 8, ...) is kept in BCD form, and it is added into the result whenever the consumed bit is 1.

The conversion ends as soon as the remaining source bits are all zero. Small numbers therefore finish in a few cycles. Zero finishes straight after the setup cycle, and values with bit 15 set take the full sixteen iterations.

A typical caller pulses `start_i` while `busy_o` is low, then waits for the one-cycle `done_o` pulse. It can then read `bcd_o` at any time until it starts the next conversion.

Top module: `bcd_conv_early`

## Requirements
- R1: After reset, busy_o, done_o and bcd_o are all zero.
- R2: A start_i sampled while busy_o is low, with a nonzero bin_i, sets busy_o high after that same clock edge.
- R3: When done_o is high, bcd_o holds the decimal value of the captured input: digit k (units is k=0) sits in bits 4k+3..4k, and every digit is in the range 0 to 9.
- R4: A start_i with bin_i equal to zero gives done_o high right after the setup edge and a result of zero, and busy_o never rises.
- R5: For a nonzero input whose highest set bit is at position p, done_o rises after exactly p+1 iteration edges following the setup edge.
- R6: Any input with bit 15 set takes the full 16 iterations, so the result appears 17 cycles after the start cycle.
- R7: done_o is high for a single cycle, and busy_o and done_o are never high together.
- R8: A start_i applied while busy_o is high is ignored: the running conversion keeps its input and its timing.
- R9: bcd_o changes only in a cycle where done_o is high, and holds its value from then until the next accepted conversion completes.
- R10: The internal decimal additions never carry out of the top digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a conversion (accepted only while idle) |
| bin_i | input | 16 | Unsigned binary value captured at start |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle pulse, result is valid |
| bcd_o | output | 20 | Five packed BCD digits, units in bits 3..0 |

## Verification
The setup edge is the clock edge that samples `start_i`. For zero, `done_o` is due directly after that edge. For any other input it is due after p+1 further edges, where p is the index of the highest set bit. `busy_o` is due straight after the setup edge.

The bench drives inputs on falling edges and counts rising edges from the setup edge, sampling each output at the following falling edge. It compares that count with the p+1 it computes for the input, and compares the result with digits it derives by repeated division by ten.

Three directed tests cover the remaining timing rules: a second start issued mid-conversion, the cycle after the done pulse, and a long idle stretch with `bin_i` changing. Each samples at the exact cycle the rules fix.

// File: rtl/bcd_conv_pkg.sv
package bcd_conv_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] bcd_digit_t;
endpackage

// File: rtl/bcd_digit_add.sv
module bcd_digit_add
  import bcd_conv_pkg::*;
(
  input  bcd_digit_t a_i,
  input  bcd_digit_t b_i,
  input  logic       cin_i,
  output bcd_digit_t sum_o,
  output logic       cout_o
);
  logic [DIGIT_W:0] raw;
  logic             fix;

  always_comb begin
    raw    = {1'b0, a_i} + {1'b0, b_i} + {{DIGIT_W{1'b0}}, cin_i};
    fix    = (raw > 5'd9);
    sum_o  = fix ? (raw[DIGIT_W-1:0] + bcd_digit_t'(6)) : raw[DIGIT_W-1:0];
    cout_o = fix;
  end
endmodule

// File: rtl/bcd_add.sv
module bcd_add
  import bcd_conv_pkg::*;
#(
  parameter int DIGITS = 5,
  localparam int W = DIGITS * DIGIT_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [DIGITS:0] carry;
  assign carry[0] = 1'b0;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    bcd_digit_add u_dig (
      .a_i   (a_i[d*DIGIT_W +: DIGIT_W]),
      .b_i   (b_i[d*DIGIT_W +: DIGIT_W]),
      .cin_i (carry[d]),
      .sum_o (sum_o[d*DIGIT_W +: DIGIT_W]),
      .cout_o(carry[d+1])
    );
  end

  assign cout_o = carry[DIGITS];
endmodule

// File: rtl/bcd_conv_early.sv
module bcd_conv_early
  import bcd_conv_pkg::*;
#(
  parameter int BIN_W  = 16,
  parameter int DIGITS = 5,
  localparam int BCD_W = DIGITS * DIGIT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [BIN_W-1:0] bin_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [BCD_W-1:0] bcd_o
);
  localparam logic [BCD_W-1:0] WT_ONE = {{(BCD_W-1){1'b0}}, 1'b1};

  logic [BIN_W-1:0] src_q;
  logic [BIN_W-1:0] src_shift;
  logic [BCD_W-1:0] wt_q, acc_q;
  logic [BCD_W-1:0] acc_sum, wt_dbl, acc_nxt;
  logic             acc_cout, dbl_cout;

  // accumulate the current weight
  bcd_add #(.DIGITS(DIGITS)) u_acc_add (
    .a_i(acc_q), .b_i(wt_q), .sum_o(acc_sum), .cout_o(acc_cout)
  );

  // decimal doubling of the weight
  bcd_add #(.DIGITS(DIGITS)) u_wt_dbl (
    .a_i(wt_q), .b_i(wt_q), .sum_o(wt_dbl), .cout_o(dbl_cout)
  );

  assign src_shift = src_q >> 1;
  assign acc_nxt   = src_q[0] ? acc_sum : acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      bcd_o  <= '0;
      src_q  <= '0;
      wt_q   <= '0;
      acc_q  <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          src_q <= bin_i;
          wt_q  <= WT_ONE;
          acc_q <= '0;
          if (bin_i == '0) begin
            done_o <= 1'b1;
            bcd_o  <= '0;
          end else begin
            busy_o <= 1'b1;
          end
        end
      end else begin
        src_q <= src_shift;
        wt_q  <= wt_dbl;
        acc_q <= acc_nxt;
        if (src_shift == '0) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
          bcd_o  <= acc_nxt;
        end
      end
    end
  end

  // R2: a nonzero start from idle raises busy
  a_r2_busy_rise: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && bin_i != '0) |=> busy_o);

  // R4: a zero input completes at once without busy
  a_r4_zero_fast: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && bin_i == '0) |=> (done_o && !busy_o));

  // R7: single-cycle done, never together with busy
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    (done_o && !(start_i && bin_i == '0)) |=> !done_o);
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o));

  // R9: result moves only together with done
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(bcd_o) |-> done_o);

  // R10: no decimal overflow in either adder during iterations
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (!(src_q[0] && acc_cout) && !dbl_cout));

  // R3: every output digit is a decimal digit
  for (genvar d = 0; d < DIGITS; d++) begin : g_chk
    a_r3_digit_range: assert property (@(posedge clk) disable iff (rst)
      bcd_o[d*DIGIT_W +: DIGIT_W] <= 4'd9);
  end
endmodule

// File: tb/bcd_conv_early_bench.sv
module bcd_conv_early_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [15:0] bin_i = '0;
  logic        busy_o, done_o;
  logic [19:0] bcd_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_conv_early u_bcd_conv_early (
    .clk(clk), .rst(rst), .start_i(start_i), .bin_i(bin_i),
    .busy_o(busy_o), .done_o(done_o), .bcd_o(bcd_o)
  );

  // {input, expected digits, expected iterations}
  localparam logic [40:0] VEC [12] = '{
    {16'd0,     20'h00000, 5'd0},
    {16'd1,     20'h00001, 5'd1},
    {16'd9,     20'h00009, 5'd4},
    {16'd10,    20'h00010, 5'd4},
    {16'd99,    20'h00099, 5'd7},
    {16'd100,   20'h00100, 5'd7},
    {16'd255,   20'h00255, 5'd8},
    {16'd256,   20'h00256, 5'd9},
    {16'd1000,  20'h01000, 5'd10},
    {16'd9999,  20'h09999, 5'd14},
    {16'd32768, 20'h32768, 5'd16},
    {16'd65535, 20'h65535, 5'd16}
  };

  function automatic logic [19:0] ref_bcd(int v);
    logic [19:0] r = '0;
    for (int d = 0; d < 5; d++) begin
      r[4*d +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  function automatic int ref_iters(int v);
    int n = 0;
    while (v != 0) begin
      v = v >> 1;
      n++;
    end
    return n;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // run one conversion; returns iteration edges counted after the setup edge
  task automatic convert(input logic [15:0] v, output int n, output logic [19:0] res,
                         output logic busy_after_setup);
    @(negedge clk);
    start_i = 1'b1;
    bin_i   = v;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    busy_after_setup = busy_o;
    n = 0;
    while (!done_o && n < 40) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    res = bcd_o;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int n;
    logic [19:0] res;
    logic bsy;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(busy_o == 1'b0 && done_o == 1'b0, "R1", "flags after reset",
          {busy_o, done_o}, 0);
    check(bcd_o == '0, "R1", "bcd after reset", bcd_o, 0);

    // table walk: R3, R5, R6, R4 for entry 0
    for (int i = 0; i < 12; i++) begin
      convert(VEC[i][40:25], n, res, bsy);
      check(res == VEC[i][24:5], "R3", "table result", res, VEC[i][24:5]);
      check(n == int'(VEC[i][4:0]), (VEC[i][4:0] == 16) ? "R6" : "R5",
            "table latency", n, VEC[i][4:0]);
      if (VEC[i][40:25] == 0)
        check(bsy == 1'b0, "R4", "busy on zero", bsy, 0);
      else
        check(bsy == 1'b1, "R2", "busy after setup", bsy, 1);
    end

    // low range exhaustively, then a spread over the full range
    for (int v = 0; v < 1024; v++) begin
      convert(16'(v), n, res, bsy);
      check(res == ref_bcd(v), "R3", "low sweep result", res, ref_bcd(v));
      check(n == ref_iters(v), "R5", "low sweep latency", n, ref_iters(v));
    end
    for (int i = 0; i < 4096; i++) begin
      int v = i * 16 + (i % 16);
      convert(16'(v), n, res, bsy);
      check(res == ref_bcd(v), "R3", "wide sweep result", res, ref_bcd(v));
      check(n == ref_iters(v), (v >= 32768) ? "R6" : "R5", "wide sweep latency",
            n, ref_iters(v));
    end

    // R7: done lasts one cycle, not with busy
    convert(16'd4321, n, res, bsy);
    check(busy_o == 1'b0, "R7", "busy during done", busy_o, 0);
    @(negedge clk);
    check(done_o == 1'b0, "R7", "done second cycle", done_o, 0);

    // R9: result held while idle and inputs wander
    bin_i = 16'd7777;
    repeat (6) @(negedge clk);
    check(bcd_o == 20'h04321, "R9", "held result", bcd_o, 20'h04321);

    // R8: start while busy ignored
    @(negedge clk);
    start_i = 1'b1;
    bin_i   = 16'hFFFF;
    @(posedge clk);
    @(negedge clk);
    n = 0;
    start_i = 1'b0;
    repeat (3) begin
      @(posedge clk); n++; @(negedge clk);
    end
    start_i = 1'b1;
    bin_i   = 16'd1;
    @(posedge clk); n++; @(negedge clk);
    start_i = 1'b0;
    while (!done_o && n < 40) begin
      @(posedge clk); n++; @(negedge clk);
    end
    check(bcd_o == 20'h65535, "R8", "result after ignored start", bcd_o, 20'h65535);
    check(n == 16, "R8", "latency after ignored start", n, 16);

    // back-to-back: start in the done cycle with zero (R4)
    start_i = 1'b1;
    bin_i   = 16'd0;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    check(done_o == 1'b1 && bcd_o == '0, "R4", "zero right after done",
          {done_o, bcd_o}, {1'b1, 20'h0});

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule